// File: doc/BRIEF.md
# Command-Queue SPI Master

This block is a single-lane SPI master whose bus activity comes only from 32-bit command entries. Software places entries in a command queue through a small register write port. Each entry does one of three things. It can move chip select with a programmable idle hold. It can shift out the entry's own 8-bit immediate, for example an opcode. It can move a counted run of bytes between the SPI lines and two word-wide data FIFOs, one for transmit and one for receive. The byte count of a run is either the immediate itself or two raised to the immediate.

Transmit words are taken apart low byte first, and receive bytes are packed low byte first. A final word that is only partly used has its unused upper bytes dropped on transmit and set to zero on receive. The shift clock runs at the reference clock divided by `2 << n`, with a 3-bit `n`. Polarity and phase select any of the four standard SPI modes. An enable bit holds the command queue, and pushes into a full queue or FIFO set sticky overflow flags.

Register write addresses: 0 = configuration (bit 1 polarity, bit 2 phase, bits [5:3] divider exponent), 1 = enable (bit 0), 2 = command push, 3 = transmit word push, 4 = status write-one-to-clear.

Top module: `cq_spi_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0 and `status` reads 0x84, meaning the command queue is empty, the transmit FIFO is not full and no flag is set.
- R2: While enable bit 0 is clear, no command entry leaves the queue, so status bit 7 stays 0 after a push and the SPI pins stay quiet. Setting the bit resumes execution.
- R3: An entry with command bits 16 and 17 both clear is a chip-select entry. It drives `cs_n` low when bit 12 is 1 and high when bit 12 is 0. It then keeps the block busy (status bit 6) for exactly imm × 2 × 2^n reference cycles, where imm is bits [7:0]. An imm of 5 is supported.
- R4: An entry with bit 16 set and bit 8 clear shifts out its bits [7:0] as one byte, most significant bit first.
- R5: An entry with bit 8 set moves imm bytes when bit 9 is 0, and 2^imm bytes when bit 9 is 1.
- R6: Transmit words are consumed least significant byte first. In a final partial word, the upper bytes are not shifted out, and the next entry starts from a fresh word.
- R7: With bit 17 set, received bytes are packed least significant byte first into 32-bit words. A final partial word is pushed with its upper bytes at zero. Receive-only runs drive MOSI high.
- R8: The SCLK period is 2 << n reference cycles, with n from configuration bits [5:3].
- R9: Configuration bit 1 (polarity) sets the idle SCLK level. Bit 2 (phase) selects sampling on the leading edge (0) or the trailing edge (1). SCLK sits at its idle level whenever the engine is idle.
- R10: Status bit 2 is transmit FIFO not full, bit 3 is transmit FIFO full, bit 4 is receive FIFO not empty, bit 6 is busy and bit 7 is command queue empty. Writing a 1 at address 4 clears the matching sticky bit.
- R11: A transmit run that finds the transmit FIFO empty holds SCLK at idle and stays busy until a word arrives, and no byte is lost.
- R12: The command queue and both data FIFOs hold 16 entries. A push into a full one is dropped and sets a sticky flag: bit 0 for commands, bit 1 for transmit, bit 5 for receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| rx_pop | input | 1 | Removes the head word of the receive FIFO |
| rx_data | output | 32 | Head word of the receive FIFO |
| status | output | 8 | Status and sticky flags |
| sclk | output | 1 | SPI shift clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check several properties on every cycle. The queue never releases an entry while the enable bit is clear. The transmit FIFO is never popped while empty. SCLK rests at its idle level whenever the engine is idle and whenever chip select moves. The transmit full and not-full flags always disagree. A push into a full transmit FIFO always raises its overflow flag.

Some behaviours can only be shown by the bench's scenarios, using an SPI slave model that captures MOSI and feeds MISO. These are the byte order inside words, the immediate and power-of-two byte counts, and the zero padding of a partial receive word. They also include the exact chip-select hold, the SCLK period, correct data in mode 3 as well as mode 0, and the stall on an empty transmit FIFO.

// File: rtl/cqspi_pkg.sv
package cqspi_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 17;

    localparam logic [2:0] REG_CFG  = 3'd0;
    localparam logic [2:0] REG_EN   = 3'd1;
    localparam logic [2:0] REG_CMD  = 3'd2;
    localparam logic [2:0] REG_TXD  = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;

    localparam int ST_OVF_CMD = 0;
    localparam int ST_OVF_TX  = 1;
    localparam int ST_TX_NF   = 2;
    localparam int ST_TX_FULL = 3;
    localparam int ST_RX_NE   = 4;
    localparam int ST_OVF_RX  = 5;
    localparam int ST_BUSY    = 6;
    localparam int ST_CMD_MT  = 7;

    typedef struct packed {
        logic [7:0] imm;
        logic       xfer;
        logic       expo;
        logic       cs_on;
        logic       tx;
        logic       rx;
    } cmd_t;

    typedef struct packed {
        logic       cpha;
        logic       cpol;
        logic [2:0] div;
    } cfg_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_HOLD, ENG_FETCH, ENG_SHIFT} eng_state_e;
    typedef enum logic [1:0] {SRC_IMM, SRC_FIFO, SRC_ONES} src_e;

    function automatic logic [LEN_W-1:0] entry_len(input logic expo, input logic [7:0] imm);
        return expo ? (LEN_W'(1) << imm) : LEN_W'(imm);
    endfunction

endpackage

// File: rtl/cqspi_fifo.sv
module cqspi_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/cqspi_engine.sv
module cqspi_engine
    import cqspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  cfg_t              cfg,
    input  logic              cmd_valid,
    input  cmd_t              cmd,
    output logic              cmd_pop,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    eng_state_e        state;
    src_e              src;
    logic [7:0]        div_cnt, half_m1, imm_q, sh, rsh, cur_byte, rx_byte;
    logic [8:0]        hold_cnt;
    logic [3:0]        ph;
    logic [LEN_W-1:0]  remain, new_len;
    logic [1:0]        tx_idx, rx_idx;
    logic [WORD_W-1:0] txw, rxw, rxw_ins;
    logic              lvl, rx_en, tick, need_word, fetch_go;

    assign half_m1   = (8'd1 << cfg.div) - 8'd1;
    assign tick      = en && (state == ENG_HOLD || state == ENG_SHIFT) && (div_cnt == half_m1);
    assign cmd_pop   = en && (state == ENG_IDLE) && cmd_valid;
    assign need_word = (src == SRC_FIFO) && (tx_idx == 2'd0);
    assign tx_pop    = en && (state == ENG_FETCH) && need_word && tx_valid;
    assign fetch_go  = en && (state == ENG_FETCH) && (!need_word || tx_valid);
    assign new_len   = entry_len(cmd.expo, cmd.imm);
    assign rx_byte   = cfg.cpha ? {rsh[6:0], miso} : rsh;
    assign rxw_ins   = rxw | (WORD_W'(rx_byte) << {rx_idx, 3'b000});
    assign busy      = (state != ENG_IDLE);
    assign sclk      = cfg.cpol ^ lvl;

    always_comb begin
        unique case (src)
            SRC_IMM:  cur_byte = imm_q;
            SRC_FIFO: cur_byte = need_word ? tx_word[7:0] : txw[{tx_idx, 3'b000} +: 8];
            default:  cur_byte = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            src      <= SRC_ONES;
            div_cnt  <= '0;
            imm_q    <= '0;
            sh       <= '0;
            rsh      <= '0;
            hold_cnt <= '0;
            ph       <= '0;
            remain   <= '0;
            tx_idx   <= '0;
            rx_idx   <= '0;
            txw      <= '0;
            rxw      <= '0;
            rx_word  <= '0;
            rx_push  <= 1'b0;
            rx_en    <= 1'b0;
            lvl      <= 1'b0;
            cs_n     <= 1'b1;
            mosi     <= 1'b1;
        end else begin
            rx_push <= 1'b0;
            unique case (state)
                ENG_IDLE: if (cmd_pop) begin
                    tx_idx  <= '0;
                    rx_idx  <= '0;
                    rxw     <= '0;
                    div_cnt <= '0;
                    if (!cmd.tx && !cmd.rx) begin
                        cs_n     <= ~cmd.cs_on;
                        hold_cnt <= {cmd.imm, 1'b0};
                        if (cmd.imm != 8'd0) state <= ENG_HOLD;
                    end else if (!cmd.xfer) begin
                        if (cmd.tx) begin
                            src    <= SRC_IMM;
                            imm_q  <= cmd.imm;
                            remain <= LEN_W'(1);
                            rx_en  <= 1'b0;
                            state  <= ENG_FETCH;
                        end
                    end else if (new_len != '0) begin
                        src    <= cmd.tx ? SRC_FIFO : SRC_ONES;
                        remain <= new_len;
                        rx_en  <= cmd.rx;
                        state  <= ENG_FETCH;
                    end
                end
                ENG_HOLD: if (en) begin
                    if (tick) begin
                        div_cnt  <= '0;
                        hold_cnt <= hold_cnt - 1'b1;
                        if (hold_cnt == 9'd1) state <= ENG_IDLE;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                ENG_FETCH: if (fetch_go) begin
                    if (src == SRC_FIFO) begin
                        if (need_word) txw <= tx_word;
                        tx_idx <= tx_idx + 1'b1;
                    end
                    if (cfg.cpha) begin
                        sh <= cur_byte;
                    end else begin
                        mosi <= cur_byte[7];
                        sh   <= {cur_byte[6:0], 1'b0};
                    end
                    ph      <= '0;
                    div_cnt <= '0;
                    lvl     <= 1'b0;
                    state   <= ENG_SHIFT;
                end
                ENG_SHIFT: if (en) begin
                    if (tick) begin
                        div_cnt <= '0;
                        lvl     <= ~lvl;
                        ph      <= ph + 1'b1;
                        if (!ph[0]) begin
                            if (cfg.cpha) begin
                                mosi <= sh[7];
                                sh   <= {sh[6:0], 1'b0};
                            end else begin
                                rsh <= {rsh[6:0], miso};
                            end
                        end else begin
                            if (cfg.cpha) begin
                                rsh <= {rsh[6:0], miso};
                            end else if (ph != 4'd15) begin
                                mosi <= sh[7];
                                sh   <= {sh[6:0], 1'b0};
                            end
                        end
                        if (ph == 4'd15) begin
                            remain <= remain - 1'b1;
                            if (rx_en) begin
                                rx_idx <= rx_idx + 1'b1;
                                if (rx_idx == 2'd3 || remain == LEN_W'(1)) begin
                                    rx_push <= 1'b1;
                                    rx_word <= rxw_ins;
                                    rxw     <= '0;
                                end else begin
                                    rxw <= rxw_ins;
                                end
                            end
                            state <= (remain == LEN_W'(1)) ? ENG_IDLE : ENG_FETCH;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cq_spi_master.sv
module cq_spi_master
    import cqspi_pkg::*;
#(
    parameter int CMD_DEPTH  = 16,
    parameter int DATA_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              rx_pop,
    output logic [WORD_W-1:0] rx_data,
    output logic [7:0]        status,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int CMD_W = $bits(cmd_t);

    cfg_t              cfg_q;
    logic              en_q, ovf_cmd, ovf_tx, ovf_rx, busy;
    cmd_t              cmd_in, cmd_head;
    logic [CMD_W-1:0]  cmd_raw;
    logic              cmd_push, cmd_pop, cmd_empty, cmd_full;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_word, rx_word;
    logic              stat_clr;

    assign cmd_in   = '{imm: reg_wdata[7:0], xfer: reg_wdata[8], expo: reg_wdata[9],
                        cs_on: reg_wdata[12], tx: reg_wdata[16], rx: reg_wdata[17]};
    assign cmd_push = reg_wr && (reg_addr == REG_CMD);
    assign tx_push  = reg_wr && (reg_addr == REG_TXD);
    assign stat_clr = reg_wr && (reg_addr == REG_STAT);
    assign cmd_head = cmd_t'(cmd_raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            en_q    <= 1'b0;
            ovf_cmd <= 1'b0;
            ovf_tx  <= 1'b0;
            ovf_rx  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == REG_CFG)
                cfg_q <= '{cpha: reg_wdata[2], cpol: reg_wdata[1], div: reg_wdata[5:3]};
            if (reg_wr && reg_addr == REG_EN)
                en_q <= reg_wdata[0];
            ovf_cmd <= (ovf_cmd && !(stat_clr && reg_wdata[ST_OVF_CMD])) || (cmd_push && cmd_full);
            ovf_tx  <= (ovf_tx  && !(stat_clr && reg_wdata[ST_OVF_TX]))  || (tx_push && tx_full);
            ovf_rx  <= (ovf_rx  && !(stat_clr && reg_wdata[ST_OVF_RX]))  || (rx_push && rx_full);
        end
    end

    assign status = {cmd_empty, busy, ovf_rx, !rx_empty, tx_full, !tx_full, ovf_tx, ovf_cmd};

    cqspi_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst(rst), .push(cmd_push), .wdata(cmd_in), .pop(cmd_pop),
        .rdata(cmd_raw), .empty(cmd_empty), .full(cmd_full));

    cqspi_fifo #(.W(WORD_W), .DEPTH(DATA_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(reg_wdata), .pop(tx_pop),
        .rdata(tx_word), .empty(tx_empty), .full(tx_full));

    cqspi_fifo #(.W(WORD_W), .DEPTH(DATA_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_word), .pop(rx_pop),
        .rdata(rx_data), .empty(rx_empty), .full(rx_full));

    cqspi_engine u_eng (
        .clk(clk), .rst(rst), .en(en_q), .cfg(cfg_q),
        .cmd_valid(!cmd_empty), .cmd(cmd_head), .cmd_pop(cmd_pop),
        .tx_valid(!tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .busy(busy),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));
endmodule

// File: rtl/cqspi_checker.sv
module cqspi_checker
    import cqspi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       cmd_pop,
    input logic       tx_pop,
    input logic       tx_empty,
    input logic       tx_full,
    input logic       busy,
    input logic       sclk,
    input logic       cs_n,
    input logic       cpol,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] status
);
    a_r2_no_pop_disabled: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !cmd_pop);

    a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty);

    a_r9_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cpol));

    a_r3_cs_moves_quiet: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n) |-> (sclk == cpol));

    a_r10_full_flags: assert property (@(posedge clk) disable iff (rst)
        status[ST_TX_NF] != status[ST_TX_FULL]);

    a_r12_tx_drop_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_TXD && tx_full) |=> status[ST_OVF_TX]);
endmodule

bind cq_spi_master cqspi_checker u_chk (
    .clk(clk), .rst(rst), .enable(en_q), .cmd_pop(cmd_pop), .tx_pop(tx_pop),
    .tx_empty(tx_empty), .tx_full(tx_full), .busy(busy), .sclk(sclk), .cs_n(cs_n),
    .cpol(cfg_q.cpol), .wr_en(reg_wr), .wr_addr(reg_addr), .status(status));

// File: tb/cq_spi_master_test.sv
module cq_spi_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rx_pop = 1'b0;
    logic [31:0] rx_data;
    logic [7:0]  status;
    logic        sclk, cs_n, mosi, miso;

    localparam int C_TX = 1 << 16, C_RX = 1 << 17, C_X = 1 << 8, C_E = 1 << 9;
    localparam int C_CS = 1 << 12, C_LANE = 1 << 10, C_BUS = 1 << 14;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic cpol_tb = 1'b0, cpha_tb = 1'b0;
    int div_tb = 0;
    bit done = 0;

    int sbits = 0, leads = 0, last_lead = 0;
    logic [7:0] cur = '0;
    logic pcs = 1'b1, psclk = 1'b0;
    logic [7:0] got [$];

    cq_spi_master uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rx_pop(rx_pop), .rx_data(rx_data), .status(status),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    always #10 clk = ~clk;

    function automatic logic [7:0] mby(input int k);
        return 8'(k * 7 + 49);
    endfunction

    function automatic logic [31:0] exp_word(input int k);
        return {mby(k + 3), mby(k + 2), mby(k + 1), mby(k)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always_comb begin
        logic [7:0] b;
        b = mby(sbits / 8);
        miso = b[7 - (sbits % 8)];
    end

    // slave model: samples MOSI on the mode's sampling edge, checks the period
    always @(cs_n or sclk) begin
        if (cs_n == 1'b0 && pcs == 1'b1) begin
            sbits = 0;
            leads = 0;
        end else if (cs_n == 1'b0 && sclk !== psclk) begin
            if (sclk != cpol_tb) begin
                if (leads % 8 != 0) chk("R8 sclk period", 32'(cyc - last_lead), 32'(2 << div_tb));
                last_lead = cyc;
                leads++;
            end
            if ((sclk != cpol_tb) == !cpha_tb) begin
                cur = {cur[6:0], mosi};
                sbits++;
                if (sbits % 8 == 0) got.push_back(cur);
            end
        end
        pcs = cs_n;
        psclk = sclk;
    end

    // per-clock reference comparison
    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            if (cs_n) chk("R9 idle sclk level", 32'(sclk), 32'(cpol_tb));
            chk("R10 full vs not-full", 32'(status[2]), 32'(!status[3]));
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        if (a == 3'd0) begin
            cpol_tb = d[1];
            cpha_tb = d[2];
            div_tb = int'(d[5:3]);
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(status[7] && !status[6]));
        repeat (4) @(negedge clk);
    endtask

    task automatic pop_rx(input string tag, input logic [31:0] exp);
        @(negedge clk);
        chk(tag, rx_data, exp);
        rx_pop = 1'b1;
        @(posedge clk);
        #1 rx_pop = 1'b0;
    endtask

    task automatic hold_count(input string tag, input int exp);
        int n = 0;
        do @(negedge clk); while (!status[6]);
        while (status[6]) begin
            n++;
            @(negedge clk);
        end
        chk(tag, 32'(n), 32'(exp));
    endtask

    initial begin
        int k0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset status", 32'(status), 32'h84);
        chk("R1 reset cs_n", 32'(cs_n), 32'd1);
        chk("R1 reset sclk", 32'(sclk), 32'd0);

        wr(3'd0, 32'(1 << 3));
        wr(3'd1, 32'd1);

        // R3 assert chip select with a 5-period hold (div 1 -> half period 2)
        wr(3'd2, C_CS | C_BUS | C_LANE | 5);
        hold_count("R3 assert hold cycles", 20);
        chk("R3 cs_n low", 32'(cs_n), 32'd0);

        // R4 immediate opcode byte
        got.delete();
        wr(3'd2, C_TX | C_CS | C_BUS | C_LANE | 8'h9F);
        wait_idle();
        chk("R4 byte count", 32'(got.size()), 32'd1);
        if (got.size() > 0) chk("R4 opcode", 32'(got[0]), 32'h9F);

        // R5/R6 six transmit bytes, partial last word
        got.delete();
        wr(3'd3, 32'h44332211);
        wr(3'd3, 32'hFFFF6655);
        wr(3'd2, C_TX | C_X | C_CS | C_LANE | 6);
        wait_idle();
        chk("R6 byte count partial word", 32'(got.size()), 32'd6);
        for (int i = 0; i < 6 && i < got.size(); i++)
            chk("R6 tx byte order", 32'(got[i]), 32'(8'h11 * (i + 1)));

        // R7 six receive bytes
        k0 = sbits / 8;
        wr(3'd2, C_RX | C_X | C_CS | C_LANE | 6);
        wait_idle();
        chk("R10 rx not empty", 32'(status[4]), 32'd1);
        pop_rx("R7 rx word 0", exp_word(k0));
        pop_rx("R7 rx partial zero pad", {16'h0, mby(k0 + 5), mby(k0 + 4)});
        @(negedge clk);
        chk("R10 rx empty after pops", 32'(status[4]), 32'd0);

        // R5 exponent count: 2^3 bytes
        k0 = sbits / 8;
        wr(3'd2, C_RX | C_X | C_E | C_CS | C_LANE | 3);
        wait_idle();
        pop_rx("R5 exp word 0", exp_word(k0));
        pop_rx("R5 exp word 1", exp_word(k0 + 4));
        @(negedge clk);
        chk("R5 exp count exact", 32'(status[4]), 32'd0);

        // R11 stall on empty transmit FIFO
        got.delete();
        wr(3'd2, C_TX | C_X | C_CS | C_LANE | 4);
        repeat (60) @(negedge clk);
        chk("R11 no bytes while starved", 32'(got.size()), 32'd0);
        chk("R11 busy while starved", 32'(status[6]), 32'd1);
        chk("R11 sclk idle while starved", 32'(sclk), 32'(cpol_tb));
        wr(3'd3, 32'hDDCCBBAA);
        wait_idle();
        chk("R11 bytes after data", 32'(got.size()), 32'd4);
        if (got.size() == 4) chk("R11 data", {got[3], got[2], got[1], got[0]}, 32'hDDCCBBAA);

        // R2 enable gating
        got.delete();
        wr(3'd1, 32'd0);
        wr(3'd2, C_TX | C_CS | C_LANE | 8'h5C);
        repeat (30) @(negedge clk);
        chk("R2 queue held", 32'(status[7]), 32'd0);
        chk("R2 no bus activity", 32'(got.size()), 32'd0);
        wr(3'd1, 32'd1);
        wait_idle();
        chk("R2 resumes", 32'(got.size()), 32'd1);
        if (got.size() > 0) chk("R2 resumed byte", 32'(got[0]), 32'h5C);

        // R3 deassert
        wr(3'd2, C_BUS | C_LANE | 5);
        hold_count("R3 deassert hold cycles", 20);
        chk("R3 cs_n high", 32'(cs_n), 32'd1);

        // R9/R8 mode 3, div 2
        wr(3'd0, (1 << 1) | (1 << 2) | (2 << 3));
        repeat (3) @(negedge clk);
        chk("R9 idle high", 32'(sclk), 32'd1);
        got.delete();
        wr(3'd2, C_CS | C_LANE | 1);
        wr(3'd2, C_TX | C_CS | C_LANE | 8'hA5);
        wr(3'd2, C_RX | C_X | C_CS | C_LANE | 1);
        wait_idle();
        if (got.size() > 0) chk("R9 mode3 tx", 32'(got[0]), 32'hA5);
        pop_rx("R9 mode3 rx", {24'h0, mby(1)});

        // R12 overflow and R10 clear
        wr(3'd1, 32'd0);
        for (int i = 0; i < 17; i++) wr(3'd3, {4{8'(i)}});
        @(negedge clk);
        chk("R12 tx full", 32'(status[3]), 32'd1);
        chk("R12 tx overflow flag", 32'(status[1]), 32'd1);
        wr(3'd4, 32'h2);
        @(negedge clk);
        chk("R10 clear tx flag", 32'(status[1]), 32'd0);
        for (int i = 0; i < 17; i++) wr(3'd2, C_CS | C_LANE);
        @(negedge clk);
        chk("R12 cmd overflow flag", 32'(status[0]), 32'd1);
        wr(3'd4, 32'h1);
        @(negedge clk);
        chk("R10 clear cmd flag", 32'(status[0]), 32'd0);
        wr(3'd1, 32'd1);
        wait_idle();
        got.delete();
        wr(3'd2, C_TX | C_X | C_E | C_CS | C_LANE | 6);
        wait_idle();
        chk("R12 sixteen words kept", 32'(got.size()), 32'd64);
        if (got.size() == 64) begin
            chk("R12 first word", 32'(got[0]), 32'd0);
            chk("R12 last kept word", 32'(got[63]), 32'd15);
        end

        k0 = sbits / 8;
        wr(3'd2, C_RX | C_X | C_CS | C_LANE | 68);
        wait_idle();
        chk("R12 rx overflow flag", 32'(status[5]), 32'd1);
        for (int i = 0; i < 16; i++) pop_rx("R12 rx kept word", exp_word(k0 + 4 * i));
        @(negedge clk);
        chk("R12 rx 17th dropped", 32'(status[4]), 32'd0);
        wr(3'd4, 32'h20);
        @(negedge clk);
        chk("R10 clear rx flag", 32'(status[5]), 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule